// File: doc/BRIEF.md
# Debug Pin Acknowledge Handshake Controller

This block runs the target side of an acknowledge handshake on a single open-drain debug wire. Upstream logic hands it one-cycle strobes for the decoded commands: handshake on, handshake off, read and write. The internal bus interface adds two strobes of its own, one for bus cycle complete and one for serial data fully received. When a command's completion conditions are met and the handshake is switched on, the block pulls the wire low for a fixed number of debug clock cycles. It then drives the wire high for one cycle to speed up the rising edge, and then releases it.

The block also watches the wire while it is not driving it. A long low level from the host is reported as a sync request. If a command is still waiting to be acknowledged when that request is seen, the command is dropped, and the block waits for the wire to return high before it accepts anything new. An acknowledge that is already on the wire is not stopped by host activity, so the two sides can drive the wire together.

Top module: `dbg_ack_ctrl`

## Requirements
- R1: After reset the handshake is off, `pin_oe`, `pin_out`, `busy` and `sync_det` are all 0, and no acknowledge is produced until a handshake-on command is accepted.
- R2: While the handshake is off, a read or write command raises `busy` from the accepting edge until the edge on which its completion conditions are met, and `pin_oe` never rises.
- R3: An accepted handshake-on command switches the handshake on and starts its own acknowledge on the same edge (`pin_oe`=1, `pin_out`=0).
- R4: Every acknowledge holds `pin_oe`=1, `pin_out`=0 for exactly ACK_LEN (default 16) cycles, then `pin_oe`=1, `pin_out`=1 for one cycle, then `pin_oe`=0.
- R5: With the handshake on, a read command starts its acknowledge on the edge where `bus_done` is sampled high after the command was accepted, and not before.
- R6: With the handshake on, a write command starts its acknowledge on the first edge by which both `bus_done` and `rx_done` have been sampled high since acceptance, in either order or in the same cycle.
- R7: An accepted handshake-off command switches the handshake off without an acknowledge, and later read and write commands produce no pulse.
- R8: `busy` stays 1 from the accepting edge until the edge on which the acknowledge releases the wire, and every command strobe that arrives while `busy` is 1 is ignored.
- R9: When `pin_in` is sampled low on SYNC_LEN (default 128) consecutive edges while the block is not driving, `sync_det` is 1 for exactly one cycle after the SYNC_LEN-th such edge. Shorter low runs produce nothing.
- R10: A sync request cancels a pending read or write (no acknowledge, `busy` drops on that edge). Command strobes are then ignored until `pin_in` is sampled high, after which the block is idle.
- R11: An acknowledge that has started always completes its low, speedup and release phases, even if the host pulls the wire low during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hs_on | input | 1 | One-cycle strobe: handshake-on command decoded |
| cmd_hs_off | input | 1 | One-cycle strobe: handshake-off command decoded |
| cmd_read | input | 1 | One-cycle strobe: read command decoded |
| cmd_write | input | 1 | One-cycle strobe: write command decoded |
| bus_done | input | 1 | One-cycle strobe: internal bus cycle finished |
| rx_done | input | 1 | One-cycle strobe: write data fully shifted in from the wire |
| pin_in | input | 1 | Sampled level of the debug wire (high when undriven) |
| pin_oe | output | 1 | Drive enable for the debug wire |
| pin_out | output | 1 | Value driven when `pin_oe` is 1 |
| busy | output | 1 | A command is pending or its acknowledge is in progress |
| sync_det | output | 1 | One-cycle indication of a host sync request |

## Verification
The assertions assume that at most one command strobe is high in any cycle, and one of them checks this. They also assume that `pin_in` is already synchronised to `clk` and that status strobes arrive in the cycles after the command they complete. The stimulus drives every strobe alone for exactly one cycle, with one exception: `bus_done` and `rx_done` are raised together once to cover that ordering. Host low pulses come only from a separate host-drive signal that is wired-AND with the block's own drive, so pin conflicts look the way they would on the real wire. A behavioural reference model predicts all four outputs and is compared against the design on every cycle, across reads, writes in three orderings, a command sent while busy, short and long host pulses, and a sync request that overlaps an acknowledge.

// File: rtl/dbg_ack_pkg.sv
package dbg_ack_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_SPEED} ack_phase_e;
  typedef enum logic [1:0] {PD_NONE, PD_READ, PD_WRITE} pend_kind_e;
endpackage

// File: rtl/dbg_ack_pulse.sv
module dbg_ack_pulse #(
  parameter int ACK_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic drv_oe,
  output logic drv_val,
  output logic active
);
  import dbg_ack_pkg::*;
  localparam int CW = (ACK_LEN > 1) ? $clog2(ACK_LEN) : 1;

  ack_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_LOW;
        cnt_d   = CW'(ACK_LEN - 1);
      end
      PH_LOW: begin
        if (cnt_q == '0) phase_d = PH_SPEED;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_SPEED: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      drv_oe  <= 1'b0;
      drv_val <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      drv_oe  <= (phase_d != PH_IDLE);
      drv_val <= (phase_d == PH_SPEED);
    end
  end

  assign active = (phase_q != PH_IDLE);

  a_r4_low_first: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_oe) |-> !drv_val);
  a_r4_speed_after_low: assert property (@(posedge clk) disable iff (rst)
    (drv_oe && !drv_val && cnt_q == '0) |=> (drv_oe && drv_val));
  a_r4_release_after_speed: assert property (@(posedge clk) disable iff (rst)
    (drv_oe && drv_val) |=> !drv_oe);
endmodule

// File: rtl/dbg_ack_cond.sv
module dbg_ack_cond (
  input  logic clk,
  input  logic rst,
  input  logic arm_rd,
  input  logic arm_wr,
  input  logic bus_done,
  input  logic rx_done,
  input  logic cancel,
  output logic pending,
  output logic done
);
  import dbg_ack_pkg::*;

  pend_kind_e kind_q;
  logic       bus_seen_q, rx_seen_q;
  logic       bus_ok, rx_ok;

  assign bus_ok  = bus_seen_q | bus_done;
  assign rx_ok   = rx_seen_q  | rx_done;
  assign done    = !cancel && (((kind_q == PD_READ) && bus_done) ||
                               ((kind_q == PD_WRITE) && bus_ok && rx_ok));
  assign pending = (kind_q != PD_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q     <= PD_NONE;
      bus_seen_q <= 1'b0;
      rx_seen_q  <= 1'b0;
    end else if (cancel || done) begin
      kind_q     <= PD_NONE;
      bus_seen_q <= 1'b0;
      rx_seen_q  <= 1'b0;
    end else if (arm_rd) begin
      kind_q     <= PD_READ;
      bus_seen_q <= 1'b0;
      rx_seen_q  <= 1'b0;
    end else if (arm_wr) begin
      kind_q     <= PD_WRITE;
      bus_seen_q <= 1'b0;
      rx_seen_q  <= 1'b0;
    end else if (kind_q != PD_NONE) begin
      bus_seen_q <= bus_ok;
      rx_seen_q  <= rx_ok;
    end
  end

  a_r5_read_waits_bus: assert property (@(posedge clk) disable iff (rst)
    (kind_q == PD_READ && done) |-> bus_done);
  a_r6_write_needs_rx: assert property (@(posedge clk) disable iff (rst)
    (kind_q == PD_WRITE && done) |-> (rx_seen_q || rx_done));
  a_r6_write_needs_bus: assert property (@(posedge clk) disable iff (rst)
    (kind_q == PD_WRITE && done) |-> (bus_seen_q || bus_done));
  a_r10_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !pending);
endmodule

// File: rtl/dbg_ack_syncdet.sv
module dbg_ack_syncdet #(
  parameter int SYNC_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_in,
  input  logic self_drive,
  output logic fire,
  output logic sync_pulse
);
  localparam int CW = $clog2(SYNC_LEN + 1);

  logic [CW-1:0] run_q;
  logic          watch_low;

  assign watch_low = !pin_in && !self_drive;
  assign fire      = watch_low && (run_q == CW'(SYNC_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= '0;
      sync_pulse <= 1'b0;
    end else begin
      if (!watch_low)                    run_q <= '0;
      else if (run_q != CW'(SYNC_LEN))   run_q <= run_q + 1'b1;
      sync_pulse <= fire;
    end
  end

  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sync_pulse |=> !sync_pulse);
  a_r9_low_seen: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_pulse) |-> $past(!pin_in));
endmodule

// File: rtl/dbg_ack_ctrl.sv
module dbg_ack_ctrl #(
  parameter int ACK_LEN  = 16,
  parameter int SYNC_LEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_hs_on,
  input  logic cmd_hs_off,
  input  logic cmd_read,
  input  logic cmd_write,
  input  logic bus_done,
  input  logic rx_done,
  input  logic pin_in,
  output logic pin_oe,
  output logic pin_out,
  output logic busy,
  output logic sync_det
);
  logic hs_on_q, hold_q;
  logic pulse_active, pend, done, fire, start;
  logic idle_ok, acc_on, acc_off, acc_rd, acc_wr;

  assign busy    = pulse_active | pend;
  assign idle_ok = !busy && !hold_q && !fire;
  assign acc_on  = idle_ok && cmd_hs_on;
  assign acc_off = idle_ok && !cmd_hs_on && cmd_hs_off;
  assign acc_rd  = idle_ok && !cmd_hs_on && !cmd_hs_off && cmd_read;
  assign acc_wr  = idle_ok && !cmd_hs_on && !cmd_hs_off && !cmd_read && cmd_write;
  assign start   = acc_on || (done && hs_on_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_on_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      if (acc_on)       hs_on_q <= 1'b1;
      else if (acc_off) hs_on_q <= 1'b0;
      if (hold_q && pin_in) hold_q <= 1'b0;
      else if (fire)        hold_q <= 1'b1;
    end
  end

  dbg_ack_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .arm_rd   (acc_rd),
    .arm_wr   (acc_wr),
    .bus_done (bus_done),
    .rx_done  (rx_done),
    .cancel   (fire),
    .pending  (pend),
    .done     (done)
  );

  dbg_ack_pulse #(.ACK_LEN(ACK_LEN)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .drv_oe  (pin_oe),
    .drv_val (pin_out),
    .active  (pulse_active)
  );

  dbg_ack_syncdet #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .pin_in     (pin_in),
    .self_drive (pin_oe),
    .fire       (fire),
    .sync_pulse (sync_det)
  );

  // input assumption: command strobes are mutually exclusive (R8 ordering)
  a_r8_cmd_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_hs_on, cmd_hs_off, cmd_read, cmd_write}));
  a_r2_no_ack_when_off: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_oe) |-> hs_on_q);
  a_r3_self_ack: assert property (@(posedge clk) disable iff (rst)
    acc_on |=> (pin_oe && !pin_out && hs_on_q));
  a_r8_drive_implies_busy: assert property (@(posedge clk) disable iff (rst)
    pin_oe |-> busy);
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> (!pin_oe && !busy));
  a_r11_low_not_cut: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && !pin_out) |=> pin_oe);
endmodule

// File: tb/dbg_ack_ctrl_tb.sv
module dbg_ack_ctrl_tb;
  localparam int ACK_LEN  = 16;
  localparam int SYNC_LEN = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_on = 0, cmd_off = 0, cmd_rd = 0, cmd_wr = 0;
  logic bus_done = 0, rx_done = 0, host_low = 0;
  logic pin_oe, pin_out, busy, sync_det;
  logic pin_in;

  int n_vec = 0, n_bad = 0, n_cyc = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  assign pin_in = !host_low && !(pin_oe && !pin_out);

  dbg_ack_ctrl #(.ACK_LEN(ACK_LEN), .SYNC_LEN(SYNC_LEN)) u_dut (
    .clk(clk), .rst(rst), .cmd_hs_on(cmd_on), .cmd_hs_off(cmd_off),
    .cmd_read(cmd_rd), .cmd_write(cmd_wr), .bus_done(bus_done),
    .rx_done(rx_done), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out),
    .busy(busy), .sync_det(sync_det)
  );

  // behavioural reference model
  bit m_on, m_hold, m_bus, m_rx;
  int m_phase, m_left, m_pend, m_run, ph;
  bit lvl, fire, done, start;
  bit e_oe, e_out, e_busy, e_sync;

  always @(posedge clk) begin
    if (rst) begin
      m_on = 0; m_hold = 0; m_bus = 0; m_rx = 0;
      m_phase = 0; m_left = 0; m_pend = 0; m_run = 0;
      e_oe = 0; e_out = 0; e_busy = 0; e_sync = 0;
    end else begin
      lvl  = !host_low && !(e_oe && !e_out);
      fire = !e_oe && !lvl && (m_run == SYNC_LEN - 1);
      if (e_oe || lvl) m_run = 0;
      else if (m_run < SYNC_LEN) m_run++;
      start = 0;
      ph = m_phase;
      if (m_phase == 1) begin
        m_left--;
        if (m_left == 0) m_phase = 2;
      end else if (m_phase == 2) m_phase = 0;
      if (m_hold) begin
        if (lvl) m_hold = 0;
      end else if (fire) begin
        m_hold = 1; m_pend = 0; m_bus = 0; m_rx = 0;
      end else if (m_pend != 0) begin
        done = (m_pend == 1 && bus_done) ||
               (m_pend == 2 && (m_bus || bus_done) && (m_rx || rx_done));
        if (done) begin
          m_pend = 0; m_bus = 0; m_rx = 0; start = m_on;
        end else begin
          m_bus = m_bus || bus_done; m_rx = m_rx || rx_done;
        end
      end else if (ph == 0) begin
        if (cmd_on) begin m_on = 1; start = 1; end
        else if (cmd_off) m_on = 0;
        else if (cmd_rd) m_pend = 1;
        else if (cmd_wr) m_pend = 2;
      end
      if (start) begin m_phase = 1; m_left = ACK_LEN; end
      e_oe   = (m_phase != 0);
      e_out  = (m_phase == 2);
      e_busy = (m_phase != 0) || (m_pend != 0);
      e_sync = fire;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, n_cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(cur_req, "pin_oe",   pin_oe,   e_oe);
      chk(cur_req, "pin_out",  pin_out,  e_out);
      chk(cur_req, "busy",     busy,     e_busy);
      chk(cur_req, "sync_det", sync_det, e_sync);
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000 && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // 0 on, 1 off, 2 read, 3 write, 4 bus_done, 5 rx_done, 6 bus+rx
  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: cmd_on = 1;  1: cmd_off = 1;  2: cmd_rd = 1;  3: cmd_wr = 1;
      4: bus_done = 1; 5: rx_done = 1;
      default: begin bus_done = 1; rx_done = 1; end
    endcase
    @(negedge clk);
    cmd_on = 0; cmd_off = 0; cmd_rd = 0; cmd_wr = 0; bus_done = 0; rx_done = 0;
  endtask

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset pin_oe", pin_oe, 1'b0);
    chk("R1", "reset busy", busy, 1'b0);
    chk("R1", "reset sync_det", sync_det, 1'b0);
    cur_req = "R2";
    pulse(2); cyc(3); pulse(4); cyc(3);
    pulse(3); pulse(5); cyc(2); pulse(4); cyc(3);
    cur_req = "R3";
    pulse(0); cyc(4);
    cur_req = "R8";
    pulse(2); cyc(2); pulse(4); cyc(16);
    cur_req = "R5";
    pulse(2); cyc(4); pulse(4); cyc(20);
    cur_req = "R4";
    pulse(2); pulse(4); cyc(20);
    cur_req = "R6";
    pulse(3); pulse(4); cyc(2); pulse(5); cyc(20);
    pulse(3); cyc(1); pulse(6); cyc(20);
    pulse(3); pulse(5); cyc(3); pulse(4); cyc(20);
    cur_req = "R10";
    pulse(2); cyc(2);
    @(negedge clk) host_low = 1;
    cyc(130); pulse(2); cyc(4);
    @(negedge clk) host_low = 0;
    cyc(2); pulse(4); cyc(4);
    cur_req = "R9";
    @(negedge clk) host_low = 1;
    cyc(100);
    @(negedge clk) host_low = 0;
    cyc(3);
    @(negedge clk) host_low = 1;
    cyc(140);
    @(negedge clk) host_low = 0;
    cyc(3);
    cur_req = "R11";
    pulse(0); cyc(3);
    @(negedge clk) host_low = 1;
    cyc(150);
    @(negedge clk) host_low = 0;
    cyc(5);
    cur_req = "R7";
    pulse(1); cyc(2); pulse(2); cyc(2); pulse(4); cyc(3);
    pulse(3); pulse(5); pulse(4); cyc(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule